// File: doc/BRIEF.md
# Branch Direction Predictor

This block holds a table of per-branch direction states, selected by low bits of a branch's instruction address. The fetch side presents a program counter and, in the same cycle, receives a taken / not-taken guess drawn from the selected entry. When a branch later resolves, the execute side presents that branch's address, the actual direction and the guess that was handed out for it. The block then steps the selected entry toward the actual direction and, one cycle later, raises a flush request if the guess was wrong.

A build-time parameter chooses between two state formats. The first is a single bit that simply remembers the last outcome. The second is a saturating two-bit counter with hysteresis, so that a single atypical outcome does not change the guess. Both formats sit behind identical ports, so they can be compared directly on the same branch stream.

Top module: `branch_predictor`

## Requirements
- R1: After reset every entry predicts not taken. In two-bit mode an entry starts as weakly not taken (01), so one taken update on a fresh entry makes it predict taken.
- R2: `lk_taken` is a combinational function of `lk_pc` and the table contents, available in the same cycle the address is presented.
- R3: The entry is selected by `pc[IDX_BITS+1:2]` (64 entries by default). Addresses that differ only in bits [1:0], or only in bits above the index, share one entry.
- R4: In one-bit mode (`MODE_HYST=0`) an update stores the actual outcome, and the next lookup of that entry returns it.
- R5: In two-bit mode the entry is a counter with 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken. Taken increments it and not taken decrements it. The guess is the counter's upper bit, so the direction flips only after two successive wrong outcomes from a strong state.
- R6: The two-bit counter saturates at 00 and at 11. Extra outcomes in the same direction leave it at the end, and two opposite outcomes are still needed to flip the guess.
- R7: When an update and a lookup select the same entry in the same cycle, the lookup returns the value held before that update.
- R8: `mispredict` is high for exactly the one cycle after a cycle with `up_valid` high and `up_outcome` different from `up_pred`. It is low otherwise. With `up_valid` low, the update inputs change no entry.
- R9: For a loop branch taken three times and then not taken, on every visit after the first, two-bit mode mispredicts once per visit and one-bit mode mispredicts twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction for `lk_pc` (1 = taken) |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_outcome | input | 1 | Actual direction (1 = taken) |
| up_pred | input | 1 | Guess that was issued for this branch |
| mispredict | output | 1 | One-cycle flush request after a wrong guess |

## Verification
Both state formats run side by side on the same stream, and each step checks the guess before the update and the flush flag after it. A repeated three-taken-one-not-taken loop separates the formats, because the single bit mispredicts on loop entry and loop exit while the counter mispredicts only on exit. A run of not-taken outcomes followed by taken outcomes on another entry shows saturation at the low end and the two-step climb back. Accesses through aliased addresses (different byte offset, different upper bits) show entry sharing, while an untouched entry keeps its state. Updates with the valid flag low, and a second reset in the middle of the run, confirm that nothing is written and that the reset state is restored.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr2_e;
endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/bp_next_state.sv
module bp_next_state #(
  parameter bit MODE_HYST = 1'b1,
  parameter int CTR_W     = 2
) (
  input  logic [CTR_W-1:0] cur,
  input  logic             outcome,
  output logic [CTR_W-1:0] nxt
);
  import bp_pkg::*;

  generate
    if (MODE_HYST) begin : g_hyst
      ctr2_e cur_e;
      ctr2_e nxt_e;
      always_comb begin
        cur_e = ctr2_e'(cur[1:0]);
        nxt_e = cur_e;
        if (outcome) begin
          if (cur_e != CTR_ST) nxt_e = ctr2_e'(cur_e + 2'd1);
        end else begin
          if (cur_e != CTR_SNT) nxt_e = ctr2_e'(cur_e - 2'd1);
        end
      end
      assign nxt = CTR_W'(nxt_e);
    end else begin : g_last
      assign nxt = CTR_W'(outcome);
    end
  endgenerate
endmodule

// File: rtl/bp_table.sv
module bp_table #(
  parameter int                  IDX_BITS = 6,
  parameter int                  CTR_W    = 2,
  parameter logic [CTR_W-1:0]    INIT     = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_BITS-1:0] rd_idx,
  output logic [CTR_W-1:0]    rd_state,
  input  logic                wr_en,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [CTR_W-1:0]    wr_state
);
  localparam int DEPTH = 1 << IDX_BITS;

  logic [CTR_W-1:0] ent_q [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      logic ent_en;
      assign ent_en = wr_en && (wr_idx == IDX_BITS'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ent_q[gi] <= INIT;
        else if (ent_en) ent_q[gi] <= wr_state;
      end
    end
  endgenerate

  assign rd_state = ent_q[rd_idx];
endmodule

// File: rtl/branch_predictor.sv
module branch_predictor #(
  parameter int PC_W      = 32,
  parameter int IDX_BITS  = 6,
  parameter bit MODE_HYST = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_outcome,
  input  logic            up_pred,
  output logic            mispredict
);
  localparam int               CTR_W = MODE_HYST ? 2 : 1;
  localparam logic [CTR_W-1:0] INIT  = MODE_HYST ? CTR_W'(1) : CTR_W'(0);
  localparam int               LSB   = 2;

  logic                srst_n;
  logic [IDX_BITS-1:0] lk_idx;
  logic [IDX_BITS-1:0] up_idx;
  logic [CTR_W-1:0]    lk_state;
  logic [CTR_W-1:0]    up_state;
  logic [CTR_W-1:0]    up_next;
  logic                misp_d;
  logic                misp_q;

  bp_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign lk_idx = lk_pc[IDX_BITS+LSB-1:LSB];
  assign up_idx = up_pc[IDX_BITS+LSB-1:LSB];

  bp_table #(.IDX_BITS(IDX_BITS), .CTR_W(CTR_W), .INIT(INIT)) u_tbl_lk (
    .clk      (clk),
    .rst_n    (srst_n),
    .rd_idx   (lk_idx),
    .rd_state (lk_state),
    .wr_en    (up_valid),
    .wr_idx   (up_idx),
    .wr_state (up_next)
  );

  bp_table #(.IDX_BITS(IDX_BITS), .CTR_W(CTR_W), .INIT(INIT)) u_tbl_up (
    .clk      (clk),
    .rst_n    (srst_n),
    .rd_idx   (up_idx),
    .rd_state (up_state),
    .wr_en    (up_valid),
    .wr_idx   (up_idx),
    .wr_state (up_next)
  );

  bp_next_state #(.MODE_HYST(MODE_HYST), .CTR_W(CTR_W)) u_nxt (
    .cur     (up_state),
    .outcome (up_outcome),
    .nxt     (up_next)
  );

  assign lk_taken = lk_state[CTR_W-1];

  always_comb begin
    misp_d = up_valid && (up_outcome != up_pred);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) misp_q <= 1'b0;
    else         misp_q <= misp_d;
  end

  assign mispredict = misp_q;
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int PC_W      = 32,
  parameter int IDX_BITS  = 6,
  parameter bit MODE_HYST = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_taken,
  input logic            up_valid,
  input logic [PC_W-1:0] up_pc,
  input logic            up_outcome,
  input logic            up_pred,
  input logic            mispredict
);
  logic [IDX_BITS-1:0] c_lk_idx;
  logic [IDX_BITS-1:0] c_up_idx;
  assign c_lk_idx = lk_pc[IDX_BITS+1:2];
  assign c_up_idx = up_pc[IDX_BITS+1:2];

  // R8: a flush request always follows a valid update with a wrong guess
  a_r8_misp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> ($past(up_valid) && ($past(up_outcome) != $past(up_pred))));

  // R8: a wrong guess on a valid update raises the flush request next cycle
  a_r8_misp_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && (up_outcome != up_pred)) |=> mispredict);

  // R2, R7: without an update the guess for a steady address holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(up_valid) && $stable(lk_pc)) |-> $stable(lk_taken));

  // R5: two equal outcomes in a row on one entry set its guess
  a_r5_two_agree: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(up_valid) && $past(up_valid, 2) &&
     ($past(up_outcome) == $past(up_outcome, 2)) &&
     ($past(c_up_idx) == $past(c_up_idx, 2)) &&
     (c_lk_idx == $past(c_up_idx)))
    |-> (lk_taken == $past(up_outcome)));

  generate
    if (!MODE_HYST) begin : g_one
      // R4: the last outcome is what the entry returns
      a_r4_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(up_valid) && (c_lk_idx == $past(c_up_idx)))
        |-> (lk_taken == $past(up_outcome)));
    end
  endgenerate
endmodule

bind branch_predictor bp_checker #(
  .PC_W(PC_W), .IDX_BITS(IDX_BITS), .MODE_HYST(MODE_HYST)
) u_bp_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .lk_pc      (lk_pc),
  .lk_taken   (lk_taken),
  .up_valid   (up_valid),
  .up_pc      (up_pc),
  .up_outcome (up_outcome),
  .up_pred    (up_pred),
  .mispredict (mispredict)
);

// File: tb/tb_branch_predictor.sv
`timescale 1ns/1ps
module tb_branch_predictor;
  localparam int PC_W = 32;
  localparam int NVEC = 23;

  // {pc[11:0], outcome, expected guess two-bit, expected guess one-bit}
  localparam logic [14:0] VEC [NVEC] = '{
    {12'h014, 1'b1, 1'b0, 1'b0}, {12'h014, 1'b1, 1'b1, 1'b1},
    {12'h014, 1'b1, 1'b1, 1'b1}, {12'h014, 1'b0, 1'b1, 1'b1},
    {12'h014, 1'b1, 1'b1, 1'b0}, {12'h014, 1'b1, 1'b1, 1'b1},
    {12'h014, 1'b1, 1'b1, 1'b1}, {12'h014, 1'b0, 1'b1, 1'b1},
    {12'h014, 1'b1, 1'b1, 1'b0}, {12'h014, 1'b1, 1'b1, 1'b1},
    {12'h014, 1'b1, 1'b1, 1'b1}, {12'h014, 1'b0, 1'b1, 1'b1},
    {12'h040, 1'b0, 1'b0, 1'b0}, {12'h040, 1'b1, 1'b0, 1'b0},
    {12'h040, 1'b1, 1'b0, 1'b1}, {12'h043, 1'b1, 1'b1, 1'b1},
    {12'h140, 1'b0, 1'b1, 1'b1},
    {12'h004, 1'b0, 1'b0, 1'b0}, {12'h004, 1'b0, 1'b0, 1'b0},
    {12'h004, 1'b1, 1'b0, 1'b0}, {12'h004, 1'b1, 1'b0, 1'b1},
    {12'h004, 1'b1, 1'b1, 1'b1},
    {12'h014, 1'b1, 1'b1, 1'b0}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic [PC_W-1:0] lk_pc;
  logic            up_valid;
  logic [PC_W-1:0] up_pc;
  logic            up_outcome;
  logic            up_pred2;
  logic            up_pred1;
  logic            taken2, taken1;
  logic            misp2, misp1;

  int checks = 0;
  int errors = 0;
  int loop_m2 = 0;
  int loop_m1 = 0;

  always #2 clk = ~clk;

  branch_predictor #(.PC_W(PC_W), .IDX_BITS(6), .MODE_HYST(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(taken2),
    .up_valid(up_valid), .up_pc(up_pc), .up_outcome(up_outcome),
    .up_pred(up_pred2), .mispredict(misp2));

  branch_predictor #(.PC_W(PC_W), .IDX_BITS(6), .MODE_HYST(1'b0)) dut_1b (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(taken1),
    .up_valid(up_valid), .up_pc(up_pc), .up_outcome(up_outcome),
    .up_pred(up_pred1), .mispredict(misp1));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    up_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // One update: guess checked before the edge, flush flag after it
  task automatic step(input logic [11:0] pc, input logic out,
                      input logic e2, input logic e1, input string req,
                      output logic m2, output logic m1);
    @(negedge clk);
    lk_pc      = PC_W'(pc);
    up_pc      = PC_W'(pc);
    up_outcome = out;
    up_pred2   = e2;
    up_pred1   = e1;
    up_valid   = 1'b1;
    #1;
    chk({req, " R7 guess two-bit"}, taken2, e2);
    chk({req, " R4 guess one-bit"}, taken1, e1);
    @(negedge clk);
    up_valid = 1'b0;
    m2 = misp2;
    m1 = misp1;
    chk({req, " R8 flush two-bit"}, misp2, e2 != out);
    chk({req, " R8 flush one-bit"}, misp1, e1 != out);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic m2, m1;
    lk_pc = '0; up_pc = '0; up_outcome = 1'b0;
    up_pred2 = 1'b0; up_pred1 = 1'b0; up_valid = 1'b0; rst_n = 1'b0;
    do_reset();

    // R1: reset state, R2: same-cycle lookup
    foreach (VEC[i]) begin
      @(negedge clk);
      lk_pc = PC_W'(VEC[i][14:3]);
      #1;
      chk("R1 R2 reset guess two-bit", taken2, 1'b0);
      chk("R1 R2 reset guess one-bit", taken1, 1'b0);
    end
    chk("R8 reset flush", misp2 | misp1, 1'b0);

    // Vector walk: R5 loop, R3 aliasing, R6 saturation
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][14:3], VEC[i][2], VEC[i][1], VEC[i][0],
           (i >= 17 && i <= 21) ? "R6 R5" : ((i >= 12 && i <= 16) ? "R3" : "R5"),
           m2, m1);
      if (i >= 4 && i <= 7) begin
        loop_m2 += int'(m2);
        loop_m1 += int'(m1);
      end
    end
    chk("R9 two-bit one miss per visit", loop_m2 == 1, 1'b1);
    chk("R9 one-bit two misses per visit", loop_m1 == 2, 1'b1);

    // R1: one taken update on a fresh two-bit entry flips it
    step(12'h008, 1'b1, 1'b0, 1'b0, "R1", m2, m1);
    step(12'h008, 1'b1, 1'b1, 1'b1, "R1", m2, m1);

    // R8: update inputs ignored while up_valid is low
    @(negedge clk);
    up_pc = PC_W'(12'h100); up_outcome = 1'b1;
    up_pred2 = 1'b0; up_pred1 = 1'b0; up_valid = 1'b0;
    lk_pc = PC_W'(12'h100);
    repeat (2) @(negedge clk);
    chk("R8 no flush without valid two-bit", misp2, 1'b0);
    chk("R8 no flush without valid one-bit", misp1, 1'b0);
    chk("R8 entry untouched two-bit", taken2, 1'b0);
    chk("R8 entry untouched one-bit", taken1, 1'b0);

    // R1: reset in mid-run restores the initial state
    do_reset();
    lk_pc = PC_W'(12'h014);
    #1;
    chk("R1 re-reset two-bit", taken2, 1'b0);
    chk("R1 re-reset one-bit", taken1, 1'b0);
    step(12'h014, 1'b1, 1'b0, 1'b0, "R1", m2, m1);
    step(12'h014, 1'b0, 1'b1, 1'b1, "R1", m2, m1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule